// File: doc/BRIEF.md
# Indexed Dual-Bank Clock Register Port

This block sits between a byte-wide host I/O decoder and the storage of a real-time clock. That storage has two banks of 128 bytes each. The primary bank holds ten time and alarm bytes, four control registers and user RAM. The secondary bank is plain battery-backed RAM. The host reaches each bank through a pair of ports. It first writes a byte position to the pointer port, then reads or writes that byte through the data port. The two pairs sit at offsets 0/1 (primary) and 2/3 (secondary).

The secondary pair can be switched off with `sec_en`. It then behaves exactly like the primary pair, so it shares the primary pointer and the primary bank. While the external counters report an update in progress, host writes to the ten time bytes are dropped. All other bytes stay writable. The clock counters write and read the time bytes through their own side port, which is never blocked.

Top module: `rtc_bank_port`

## Requirements
- R1: During and right after reset, both pointers are 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: A write to offset 0 stores bits 6:0 of `wr_data` as the primary pointer. A read of offset 0 returns `{1'b0, pointer}`.
- R3: A write or read at offset 1 accesses the primary-bank byte selected by the primary pointer.
- R4: With `sec_en`=1, offsets 2 and 3 use a separate secondary pointer and the secondary bank. They leave the primary pointer and the primary bank untouched, and a read of offset 2 returns `{1'b0, secondary pointer}`.
- R5: With `sec_en`=0, offsets 2 and 3 act exactly as offsets 0 and 1, and the secondary pointer keeps its value.
- R6: While `upd_busy`=1, a host write to primary bytes 00h to 09h is dropped.
- R7: While `upd_busy`=1, host writes to primary bytes 0Ah to 7Fh and to any secondary byte still take effect.
- R8: Every read strobe produces `rd_valid`=1 with the data on the next cycle. With no strobe, `rd_valid` is 0 on the next cycle.
- R9: A counter-side write (`cnt_we`, 4-bit `cnt_idx`) updates primary byte `cnt_idx` whatever the state of `upd_busy`, and wins over a host write to the same byte in the same cycle. `cnt_rdata` shows primary byte `cnt_ridx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_en | input | 1 | Enables the secondary port pair |
| upd_busy | input | 1 | Update cycle in progress |
| bus_off | input | 2 | Port offset 0..3 |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Host read data, registered |
| rd_valid | output | 1 | Read data valid |
| cnt_we | input | 1 | Counter-side write strobe |
| cnt_idx | input | 4 | Counter-side write byte |
| cnt_wdata | input | 8 | Counter-side write data |
| cnt_ridx | input | 4 | Counter-side read byte |
| cnt_rdata | output | 8 | Counter-side read data |

## Verification
The bench writes the same position in both banks and reads each one back. A design that mixed up the banks or the pointers would return the other bank's value. With the secondary pair disabled, it writes through offsets 2/3 and then re-enables the pair. This checks that the alias went to the primary pointer and that the secondary pointer kept its value. The update guard is tested on each side of its boundary (09h and 0Ah) and on the secondary bank. An off-by-one guard either drops a control-register write or lets a time-byte write through. A same-cycle counter and host write to one byte checks that the counter wins.

// File: rtl/rtc_bank_port.sv
module rtc_bank_port #(
  parameter int DW = 8,
  parameter int AW = 7,
  parameter int CW = 4,
  parameter int TIME_BYTES = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_en,
  input  logic          upd_busy,
  input  logic [1:0]    bus_off,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_idx,
  input  logic [DW-1:0] cnt_wdata,
  input  logic [CW-1:0] cnt_ridx,
  output logic [DW-1:0] cnt_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] pri_mem [DEPTH];
  logic [DW-1:0] sec_mem [DEPTH];
  logic [AW-1:0] pri_ptr, sec_ptr;

  logic [1:0] eff_off;
  logic       pri_ptr_we, sec_ptr_we, host_pri_we, host_sec_we, time_hit;
  logic [AW-1:0] cnt_addr, cnt_raddr;
  logic [DW-1:0] rd_next;

  assign eff_off     = sec_en ? bus_off : {1'b0, bus_off[0]};
  assign time_hit    = pri_ptr < AW'(TIME_BYTES);
  assign pri_ptr_we  = bus_wr && eff_off == 2'd0;
  assign sec_ptr_we  = bus_wr && eff_off == 2'd2;
  assign host_pri_we = bus_wr && eff_off == 2'd1 && !(upd_busy && time_hit);
  assign host_sec_we = bus_wr && eff_off == 2'd3;
  assign cnt_addr    = AW'(cnt_idx);
  assign cnt_raddr   = AW'(cnt_ridx);
  assign cnt_rdata   = pri_mem[cnt_raddr];

  always_comb begin
    case (eff_off)
      2'd0:    rd_next = DW'(pri_ptr);
      2'd1:    rd_next = pri_mem[pri_ptr];
      2'd2:    rd_next = DW'(sec_ptr);
      default: rd_next = sec_mem[sec_ptr];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_ptr  <= '0;
      sec_ptr  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (pri_ptr_we) pri_ptr <= wr_data[AW-1:0];
      if (sec_ptr_we) sec_ptr <= wr_data[AW-1:0];
      rd_valid <= bus_rd;
      if (bus_rd) rd_data <= rd_next;
    end
  end

  always_ff @(posedge clk) begin
    if (host_pri_we) pri_mem[pri_ptr] <= wr_data;
    if (cnt_we)      pri_mem[cnt_addr] <= cnt_wdata;
    if (host_sec_we) sec_mem[sec_ptr] <= wr_data;
  end

  // R8
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);
  // R8
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !rd_valid);
  // R2
  pri_ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == 2'd0) |=> pri_ptr == $past(wr_data[AW-1:0]));
  // R4
  sec_keeps_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sec_en && bus_off == 2'd2) |=> $stable(pri_ptr));
  // R5
  alias_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !sec_en && bus_off == 2'd2) |=>
      (pri_ptr == $past(wr_data[AW-1:0]) && $stable(sec_ptr)));
  // R6
  time_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_busy && pri_ptr < AW'(TIME_BYTES)) |-> !host_pri_we);
endmodule

// File: tb/rtc_bank_port_test.sv
module rtc_bank_port_test;
  logic clk = 0, rst_n = 0, sec_en = 1, upd_busy = 0;
  logic [1:0] bus_off = 0;
  logic bus_wr = 0, bus_rd = 0, cnt_we = 0;
  logic [7:0] wr_data = 0, cnt_wdata = 0;
  logic [3:0] cnt_idx = 0, cnt_ridx = 0;
  logic [7:0] rd_data, cnt_rdata;
  logic rd_valid;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  rtc_bank_port uut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] off, logic [7:0] d);
    @(negedge clk);
    bus_off = off; wr_data = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] off, logic [7:0] exp, string req);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(req);
    bus_off = off; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R8: unexpected rd_valid data %02h expected none", rd_data);
      end else begin
        string t;
        logic [7:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {7'd0, rd_valid}, 8'h00);
    check("R1", rd_data, 8'h00);
    rst_n = 1;
    rd(2'd0, 8'h00, "R1");
    rd(2'd2, 8'h00, "R1");
    // R2: only bits 6:0 kept
    wr(2'd0, 8'hC5);
    rd(2'd0, 8'h45, "R2");
    // R3
    wr(2'd1, 8'hA1);
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h5B);
    wr(2'd0, 8'h45);
    rd(2'd1, 8'hA1, "R3");
    wr(2'd0, 8'h20);
    rd(2'd1, 8'h5B, "R3");
    // R4
    wr(2'd2, 8'h45);
    wr(2'd3, 8'h77);
    rd(2'd3, 8'h77, "R4");
    rd(2'd0, 8'h20, "R4");
    wr(2'd0, 8'h45);
    rd(2'd1, 8'hA1, "R4");
    rd(2'd2, 8'h45, "R4");
    // R5
    sec_en = 0;
    wr(2'd2, 8'h10);
    rd(2'd0, 8'h10, "R5");
    wr(2'd3, 8'h99);
    rd(2'd1, 8'h99, "R5");
    rd(2'd2, 8'h10, "R5");
    sec_en = 1;
    rd(2'd2, 8'h45, "R5");
    rd(2'd3, 8'h77, "R5");
    // R6
    wr(2'd0, 8'h03); wr(2'd1, 8'h12);
    upd_busy = 1; wr(2'd1, 8'h34); upd_busy = 0;
    rd(2'd1, 8'h12, "R6");
    wr(2'd0, 8'h09); wr(2'd1, 8'h21);
    upd_busy = 1; wr(2'd1, 8'h55); upd_busy = 0;
    rd(2'd1, 8'h21, "R6");
    // R7
    upd_busy = 1;
    wr(2'd0, 8'h0A); wr(2'd1, 8'h6C);
    wr(2'd0, 8'h7F); wr(2'd1, 8'hE3);
    wr(2'd2, 8'h02); wr(2'd3, 8'h3D);
    upd_busy = 0;
    rd(2'd1, 8'hE3, "R7");
    wr(2'd0, 8'h0A);
    rd(2'd1, 8'h6C, "R7");
    rd(2'd3, 8'h3D, "R7");
    // R9: counter write during update
    upd_busy = 1;
    @(negedge clk); cnt_we = 1; cnt_idx = 4'd3; cnt_wdata = 8'h40;
    @(negedge clk); cnt_we = 0;
    upd_busy = 0;
    cnt_ridx = 4'd3;
    #1 check("R9", cnt_rdata, 8'h40);
    wr(2'd0, 8'h03);
    rd(2'd1, 8'h40, "R9");
    // R9: counter wins same-cycle collision
    wr(2'd0, 8'h00);
    @(negedge clk);
    bus_off = 2'd1; wr_data = 8'h11; bus_wr = 1;
    cnt_we = 1; cnt_idx = 4'd0; cnt_wdata = 8'h22;
    @(negedge clk);
    bus_wr = 0; cnt_we = 0; cnt_ridx = 4'd0;
    #1 check("R9", cnt_rdata, 8'h22);
    rd(2'd1, 8'h22, "R9");
    // R8: idle cycle gives no valid
    @(negedge clk);
    check("R8", {7'd0, rd_valid}, 8'h00);
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R8: got %0d pending expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule